// File: doc/BRIEF.md
# Bimodal Branch Direction and Target Predictor

This block gives the fetch stage a guess for each fetched PC: taken or not taken, and the PC to fetch next. It holds two tables, and the fetch PC indexes both with the two alignment bits dropped. The larger table holds a 2-bit saturating counter per entry. The high bit of the counter gives the direction. The smaller table holds the last taken target seen at its index, together with a valid bit.

A lookup presented in one cycle gives its prediction on the outputs in the following cycle. A resolved branch arrives on the update inputs with its PC, its outcome and its actual target. The update steps the counter at that PC's index. If the branch was taken, the update also records the target and marks the target entry valid. The surrounding pipeline does the fetching, the branch execution and the recovery. This block only stores history and answers lookups.

Top module: `bp_predictor`

## Requirements
- R1: After reset every counter holds 2'b01, which predicts not taken, and every target entry is invalid. No prediction is output while reset is held or in the first cycle after it.
- R2: A lookup with `lk_valid_i` high produces `pr_valid_o` high exactly one cycle later. Without a lookup, `pr_valid_o` stays low. `pr_taken_o` is never high while `pr_valid_o` is low.
- R3: `pr_taken_o` equals bit 1 of the counter selected by PC bits [CTR_IDX_W+1:2] of the lookup: 1 means taken and 0 means not taken.
- R4: A taken update increments the selected counter, and the increment stops at 2'b11. A not-taken update decrements it, and the decrement stops at 2'b00.
- R5: A counter at 2'b11 needs two not-taken updates in a row before it predicts not taken. A counter at 2'b00 needs two taken updates in a row before it predicts taken.
- R6: `pr_next_pc_o` is the buffered target when the prediction is taken and the selected target entry is valid. In every other case it is the lookup PC plus 4.
- R7: Only a taken update writes the target entry at PC bits [TGT_IDX_W+1:2] and sets it valid. A not-taken update leaves the target entry unchanged.
- R8: The two tables are indexed independently. PCs that share target index bits but differ in counter index bits share one target entry and keep separate counters. PCs that differ only above bit CTR_IDX_W+1 share a counter.
- R9: When a lookup and an update select the same entries in the same cycle, the prediction reflects the table contents from before that update.
- R10: PC bits [1:0] do not affect the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | PC being fetched |
| up_valid_i | input | 1 | Resolved branch update strobe |
| up_pc_i | input | 32 | PC of the resolved branch |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |
| up_target_i | input | 32 | Resolved target address |
| pr_valid_o | output | 1 | Prediction valid, one cycle after the lookup |
| pr_taken_o | output | 1 | Predicted direction |
| pr_next_pc_o | output | 32 | Predicted next fetch PC |

## Verification
A wrong counter value shows up as a wrong `pr_taken_o` on the first lookup of that index after the fault. A wrong counter step may stay hidden until enough updates of one direction push the counter across the 01/10 boundary, so the bench drives runs of updates into both saturated ends. A lost or misplaced target write shows up only on a taken lookup whose target entry is valid, as a wrong `pr_next_pc_o`. Aliased PCs are used to expose a write to the wrong table row. A read-during-write ordering fault shows up on the very next cycle, because the bench looks up and updates the same index together.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int PC_W    = 32;
    localparam int ALIGN_W = 2;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        CTR_NT_STRONG = 2'b00,
        CTR_NT_WEAK   = 2'b01,
        CTR_T_WEAK    = 2'b10,
        CTR_T_STRONG  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic valid;
        pc_t  pc;
    } lookup_req_t;

    typedef struct packed {
        logic valid;
        pc_t  pc;
        logic taken;
        pc_t  target;
    } resolve_t;

    typedef struct packed {
        logic valid;
        logic taken;
        pc_t  next_pc;
    } predict_t;

    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_T_STRONG) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_NT_STRONG) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(4);
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 2048,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ctr_e             rd_state_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_taken_i
);

    ctr_e ctr_q [ENTRIES];
    ctr_e rd_state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= CTR_NT_WEAK;
            end
        end else if (wr_en_i) begin
            ctr_q[wr_idx_i] <= ctr_step(ctr_q[wr_idx_i], wr_taken_i);
        end
    end

    // Read samples the array before this edge's write lands.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_state_q <= CTR_NT_WEAK;
        end else if (rd_en_i) begin
            rd_state_q <= ctr_q[rd_idx_i];
        end
    end

    assign rd_state_o = rd_state_q;

endmodule

// File: rtl/bp_tgt_table.sv
module bp_tgt_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_hit_o,
    output pc_t              rd_tgt_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  pc_t              wr_tgt_i
);

    logic [ENTRIES-1:0] vld_q;
    pc_t                tgt_q [ENTRIES];
    logic               hit_q;
    pc_t                out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            tgt_q[wr_idx_i] <= wr_tgt_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hit_q <= 1'b0;
            out_q <= '0;
        end else if (rd_en_i) begin
            hit_q <= vld_q[rd_idx_i];
            out_q <= tgt_q[rd_idx_i];
        end
    end

    assign rd_hit_o = hit_q;
    assign rd_tgt_o = out_q;

endmodule

// File: rtl/bp_next_pc_sel.sv
module bp_next_pc_sel
    import bp_pkg::*;
(
    input  logic     valid_i,
    input  pc_t      pc_i,
    input  ctr_e     state_i,
    input  logic     hit_i,
    input  pc_t      tgt_i,
    output predict_t pred_o
);

    logic dir_taken;

    always_comb begin
        dir_taken      = valid_i & state_i[1];
        pred_o.valid   = valid_i;
        pred_o.taken   = dir_taken;
        pred_o.next_pc = (dir_taken && hit_i) ? tgt_i : seq_pc(pc_i);
    end

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
    import bp_pkg::*;
#(
    parameter int CTR_ENTRIES = 2048,
    parameter int TGT_ENTRIES = 256
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            lk_valid_i,
    input  logic [PC_W-1:0] lk_pc_i,
    input  logic            up_valid_i,
    input  logic [PC_W-1:0] up_pc_i,
    input  logic            up_taken_i,
    input  logic [PC_W-1:0] up_target_i,
    output logic            pr_valid_o,
    output logic            pr_taken_o,
    output logic [PC_W-1:0] pr_next_pc_o
);

    localparam int CTR_IDX_W = $clog2(CTR_ENTRIES);
    localparam int TGT_IDX_W = $clog2(TGT_ENTRIES);

    lookup_req_t lk;
    resolve_t    up;
    predict_t    pred;

    logic        lk_valid_q;
    pc_t         lk_pc_q;
    ctr_e        rd_state;
    logic        rd_hit;
    pc_t         rd_tgt;
    logic        unused_up_bits;

    assign lk.valid  = lk_valid_i;
    assign lk.pc     = lk_pc_i;
    assign up.valid  = up_valid_i;
    assign up.pc     = up_pc_i;
    assign up.taken  = up_taken_i;
    assign up.target = up_target_i;

    assign unused_up_bits = ^{up.pc[PC_W-1:ALIGN_W+CTR_IDX_W], up.pc[ALIGN_W-1:0]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lk_valid_q <= 1'b0;
            lk_pc_q    <= '0;
        end else begin
            lk_valid_q <= lk.valid;
            if (lk.valid) lk_pc_q <= lk.pc;
        end
    end

    bp_ctr_table #(.ENTRIES(CTR_ENTRIES)) ctr_tbl_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rd_en_i    (lk.valid),
        .rd_idx_i   (lk.pc[ALIGN_W +: CTR_IDX_W]),
        .rd_state_o (rd_state),
        .wr_en_i    (up.valid),
        .wr_idx_i   (up.pc[ALIGN_W +: CTR_IDX_W]),
        .wr_taken_i (up.taken)
    );

    bp_tgt_table #(.ENTRIES(TGT_ENTRIES)) tgt_tbl_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rd_en_i  (lk.valid),
        .rd_idx_i (lk.pc[ALIGN_W +: TGT_IDX_W]),
        .rd_hit_o (rd_hit),
        .rd_tgt_o (rd_tgt),
        .wr_en_i  (up.valid & up.taken),
        .wr_idx_i (up.pc[ALIGN_W +: TGT_IDX_W]),
        .wr_tgt_i (up.target)
    );

    bp_next_pc_sel sel_i (
        .valid_i (lk_valid_q),
        .pc_i    (lk_pc_q),
        .state_i (rd_state),
        .hit_i   (rd_hit),
        .tgt_i   (rd_tgt),
        .pred_o  (pred)
    );

    assign pr_valid_o   = pred.valid;
    assign pr_taken_o   = pred.taken;
    assign pr_next_pc_o = pred.next_pc;

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         lk_valid_i,
    input logic [W-1:0] lk_pc_i,
    input logic         pr_valid_o,
    input logic         pr_taken_o,
    input logic [W-1:0] pr_next_pc_o
);

    AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !pr_valid_o); // R1

    AST_PRED_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        lk_valid_i |=> pr_valid_o); // R2

    AST_PRED_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (rst_i)
        !lk_valid_i |=> !pr_valid_o); // R2

    AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        pr_taken_o |-> pr_valid_o); // R2

    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk_i) disable iff (rst_i)
        (pr_valid_o && !pr_taken_o) |-> (pr_next_pc_o == $past(lk_pc_i) + W'(4))); // R6

    AST_REDIRECT_NEEDS_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (pr_valid_o && (pr_next_pc_o != $past(lk_pc_i) + W'(4))) |-> pr_taken_o); // R3

endmodule

bind bp_predictor bp_predictor_chk #(.W(bp_pkg::PC_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .lk_valid_i   (lk_valid_i),
    .lk_pc_i      (lk_pc_i),
    .pr_valid_o   (pr_valid_o),
    .pr_taken_o   (pr_taken_o),
    .pr_next_pc_o (pr_next_pc_o)
);

// File: tb/bp_predictor_tb_top.sv
`timescale 1ns/1ps
module bp_predictor_tb_top;

    localparam int CN   = 2048;
    localparam int TN   = 256;
    localparam int CIW  = $clog2(CN);
    localparam int TIW  = $clog2(TN);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;
    logic        pr_valid;
    logic        pr_taken;
    logic [31:0] pr_next_pc;

    always #4 clk = ~clk;

    bp_predictor #(.CTR_ENTRIES(CN), .TGT_ENTRIES(TN)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .lk_valid_i(lk_valid), .lk_pc_i(lk_pc),
        .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken), .up_target_i(up_target),
        .pr_valid_o(pr_valid), .pr_taken_o(pr_taken), .pr_next_pc_o(pr_next_pc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0]  m_ctr [CN];
    logic        m_vld [TN];
    logic [31:0] m_tgt [TN];

    logic        q_taken [$];
    logic [31:0] q_npc   [$];
    string       q_req   [$];

    function automatic logic [CIW-1:0] cidx(input logic [31:0] pc);
        return pc[2 +: CIW];
    endfunction
    function automatic logic [TIW-1:0] tidx(input logic [31:0] pc);
        return pc[2 +: TIW];
    endfunction

    task automatic step(input logic lv, input logic [31:0] lpc,
                        input logic uv, input logic [31:0] upc,
                        input logic ut, input logic [31:0] utg, input string req);
        @(negedge clk);
        if (lv) begin
            logic tk;
            tk = m_ctr[cidx(lpc)][1];
            q_taken.push_back(tk);
            q_npc.push_back((tk && m_vld[tidx(lpc)]) ? m_tgt[tidx(lpc)] : lpc + 32'd4);
            q_req.push_back(req);
        end
        if (uv) begin
            if (ut) begin
                if (m_ctr[cidx(upc)] != 2'b11) m_ctr[cidx(upc)] = m_ctr[cidx(upc)] + 2'd1;
                m_vld[tidx(upc)] = 1'b1;
                m_tgt[tidx(upc)] = utg;
            end else if (m_ctr[cidx(upc)] != 2'b00) begin
                m_ctr[cidx(upc)] = m_ctr[cidx(upc)] - 2'd1;
            end
        end
        lk_valid = lv; lk_pc = lpc;
        up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
    endtask

    task automatic look(input logic [31:0] pc, input string req);
        step(1'b1, pc, 1'b0, '0, 1'b0, '0, req);
    endtask
    task automatic upd(input logic [31:0] pc, input logic t, input logic [31:0] tg);
        step(1'b0, '0, 1'b1, pc, t, tg, "");
    endtask
    task automatic idle();
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, "");
    endtask

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (!rst) begin
                if (pr_valid) begin
                    if (q_taken.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R2 prediction with no lookup: actual valid=1 expected valid=0");
                    end else begin
                        logic et; logic [31:0] en; string r;
                        et = q_taken.pop_front(); en = q_npc.pop_front(); r = q_req.pop_front();
                        checks++;
                        if (pr_taken !== et || pr_next_pc !== en) begin
                            errors++;
                            $display("FAIL %s actual taken=%0b npc=%h expected taken=%0b npc=%h",
                                     r, pr_taken, pr_next_pc, et, en);
                        end
                    end
                end else if (q_taken.size() != 0) begin
                    checks++; errors++;
                    $display("FAIL R2 missing prediction: actual valid=0 expected valid=1");
                    void'(q_taken.pop_front()); void'(q_npc.pop_front()); void'(q_req.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] A, B, C, D;
        for (int i = 0; i < CN; i++) m_ctr[i] = 2'b01;
        for (int i = 0; i < TN; i++) begin m_vld[i] = 1'b0; m_tgt[i] = '0; end
        A = 32'h0000_1000; B = A + 32'd1024; C = A + 32'd8192; D = 32'h0000_3000;

        repeat (3) @(negedge clk);
        checks++;
        if (pr_valid !== 1'b0) begin
            errors++; $display("FAIL R1 valid during reset: actual %0b expected 0", pr_valid);
        end
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        checks++;
        if (pr_valid !== 1'b0) begin
            errors++; $display("FAIL R1 valid after reset: actual %0b expected 0", pr_valid);
        end

        look(32'h0000_0100, "R1 reset counter");
        look(A, "R1 reset target");
        // R4/R3/R6 training
        upd(A, 1'b1, 32'h0000_2000);
        look(A, "R6 taken uses target");
        upd(A, 1'b1, 32'h0000_2000);
        upd(A, 1'b1, 32'h0000_2000);
        look(A, "R4 saturate high");
        // R7 not-taken keeps target; R5 first miss keeps direction
        upd(A, 1'b0, 32'h0000_9999);
        look(A, "R7 R5 one miss from 11");
        upd(A, 1'b0, 32'h0000_9999);
        look(A, "R5 second miss flips");
        upd(A, 1'b0, '0);
        upd(A, 1'b0, '0);
        upd(A, 1'b1, 32'h0000_2400);
        look(A, "R5 one taken from 00");
        upd(A, 1'b1, 32'h0000_2400);
        look(A, "R4 second taken from 00");
        // R10 low bits
        look(A + 32'd1, "R10 pc bit0");
        look(A + 32'd3, "R10 pc bits 1:0");
        // R8 aliasing
        look(B, "R8 shared target separate counter");
        look(C, "R8 shared counter");
        upd(B, 1'b1, 32'h0000_5550);
        look(A, "R8 target overwritten by alias");
        look(B, "R8 alias counter");
        // R9 same-cycle lookup and update
        step(1'b1, D, 1'b1, D, 1'b1, 32'h0000_7000, "R9 read before write");
        look(D, "R9 after write");
        idle();
        // mixed stream
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] p1, p2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p1 = 32'h0000_4000 + {19'd0, lfsr[2:0], 10'd0} + {30'd0, lfsr[9:8]};
            p2 = 32'h0000_4000 + {19'd0, lfsr[5:3], 10'd0};
            step(lfsr[6], p1, lfsr[7], p2, lfsr[11], {16'h0000, lfsr}, "R3 R4 R6 mixed stream");
        end
        idle(); idle(); idle();
        checks++;
        if (q_taken.size() != 0) begin
            errors++; $display("FAIL R2 pending predictions: actual %0d expected 0", q_taken.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule